// File: doc/BRIEF.md
# Registered Command Buffer with Parity

This block registers a memory-module command and address bus. Every rising clock edge starts a new slot. The slot is made of the parity-covered data inputs, a few control inputs that parity does not cover, and two active-low chip selects. The parity bit for a slot arrives `PAR_DLY` clocks after its data. One clock after that, the slot reaches the registered outputs. At that point the block also drives a partial parity output and updates an active-low error flag.

Parity is odd. The covered data bits and the parity bit together must hold an odd number of ones. When a slot fails the check, the error flag drops and stays low for `HOLD_CYC` clocks. A second failure during that time starts the count again. When both chip selects of a slot are HIGH, that slot does not change the data outputs or the partial parity output. The parity check and the error flag keep running. The control and chip-select outputs still follow their inputs.

An asynchronous active-low reset clears everything and overrides the chip-select gating. The block can be cascaded to cover a wider bus. The partial parity output of an instance with `PAR_DLY = 1` feeds the parity input of an instance with `PAR_DLY = 3`. In that setup only the second instance's error flag is meaningful.

Top module: `cmd_reg_par`

## Requirements
- R1: While `rst_n` is LOW, `dout`, `ppo`, `ctl_out`, `cs_a_out_n` and `cs_b_out_n` are all 0, and `err_n` is 1.
- R2: Take a slot captured at edge k in which at least one chip select is LOW. After edge k+PAR_DLY+1, `dout` equals that slot's `din`.
- R3: After edge k+PAR_DLY+1, `ppo` of an ungated slot equals the XOR of that slot's `din` bits with the `par_in` value sampled at edge k+PAR_DLY.
- R4: A slot fails the check when the value in R3 is 0 (even parity). After edge k+PAR_DLY+1, `err_n` is LOW and stays LOW for exactly HOLD_CYC clock cycles.
- R5: A failing slot that arrives while `err_n` is already LOW restarts the HOLD_CYC count from that slot's output edge.
- R6: `ctl_in`, `cs_a_n` and `cs_b_n` have no effect on `ppo` or `err_n`. `ctl_out`, `cs_a_out_n` and `cs_b_out_n` show the slot's values with the same latency as `dout`, whether or not the slot is gated.
- R7: For a slot with `cs_a_n` = 1 and `cs_b_n` = 1, `dout` and `ppo` keep their previous values at that slot's output edge.
- R8: A gated slot is still parity-checked, and a failure in it drives `err_n` LOW as in R4.
- R9: Driving `rst_n` LOW at any time forces the R1 values at once, without a clock edge, even while chip-select gating is active.
- R10: After reset is released, no output changes before edge PAR_DLY+1. In particular `err_n` stays HIGH even while `din` and `par_in` are 0.
- R11: In a cascade, the `ppo` of a `PAR_DLY = 1` instance drives the `par_in` of a `PAR_DLY = 3` instance that is fed in the same cycles. The second instance's `err_n` drops 4 edges after a slot exactly when the ones across both data buses plus the first `par_in` add up to an even count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active LOW |
| din | input | DATA_W | Data bits covered by parity |
| ctl_in | input | CTRL_W | Control bits not covered by parity (clock enable, termination) |
| cs_a_n | input | 1 | First chip select, active LOW |
| cs_b_n | input | 1 | Second chip select, active LOW |
| par_in | input | 1 | Parity bit, sampled PAR_DLY clocks after its data |
| dout | output | DATA_W | Registered data |
| ctl_out | output | CTRL_W | Registered control bits |
| cs_a_out_n | output | 1 | Registered first chip select |
| cs_b_out_n | output | 1 | Registered second chip select |
| ppo | output | 1 | Partial parity of the slot, for cascading |
| err_n | output | 1 | Parity error flag, active LOW, held HOLD_CYC cycles |

## Verification
Internal faults in this block show up at the ports within a few edges.

- A wrong valid marker in the slot pipeline shows as an `err_n` drop at edge PAR_DLY+1 after reset, when all-zero inputs are being fed.
- A freeze bit taken from the wrong stage lets `dout` or `ppo` change on a gated slot's output edge, or stay put on the edge after it.
- An off-by-one in the hold counter makes `err_n` one cycle too short or too long, which is visible within HOLD_CYC+1 edges of the failing slot.
- A parity bit sampled at the wrong edge pairs one slot's data with its neighbour's parity. The bench catches this with data whose parity alternates from slot to slot.

// File: rtl/crp_pkg.sv
package crp_pkg;

    // Width of the error hold counter; HOLD_CYC must fit in it.
    typedef logic [3:0] hold_t;

    typedef struct packed {
        logic  err_n;
        hold_t cnt;
    } flag_t;

    // A failing slot reloads the full span; otherwise count down to zero.
    function automatic hold_t hold_next(input logic hit, input hold_t cur, input hold_t span);
        hold_t nxt;
        if (hit) begin
            nxt = span;
        end else if (cur != hold_t'(0)) begin
            nxt = cur - hold_t'(1);
        end else begin
            nxt = hold_t'(0);
        end
        return nxt;
    endfunction

endpackage

// File: rtl/crp_slot_pipe.sv
module crp_slot_pipe #(
    parameter int DATA_W = 22,
    parameter int CTRL_W = 2,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic [CTRL_W-1:0] ctl_in,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    output logic              tail_vld,
    output logic              tail_frz,
    output logic [DATA_W-1:0] tail_data,
    output logic [CTRL_W-1:0] tail_ctl,
    output logic [1:0]        tail_cs
);

    typedef struct packed {
        logic              vld;
        logic              frz;
        logic [1:0]        cs_n;
        logic [CTRL_W-1:0] ctl;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t [STAGES-1:0] stg_d;
    slot_t [STAGES-1:0] stg_q;

    always_comb begin
        stg_d[0].vld  = 1'b1;
        stg_d[0].frz  = cs_a_n & cs_b_n;
        stg_d[0].cs_n = {cs_b_n, cs_a_n};
        stg_d[0].ctl  = ctl_in;
        stg_d[0].data = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign tail_vld  = stg_q[STAGES-1].vld;
    assign tail_frz  = stg_q[STAGES-1].frz;
    assign tail_data = stg_q[STAGES-1].data;
    assign tail_ctl  = stg_q[STAGES-1].ctl;
    assign tail_cs   = stg_q[STAGES-1].cs_n;

endmodule

// File: rtl/crp_par_check.sv
module crp_par_check #(
    parameter int DATA_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_in,
    input  logic              tail_vld,
    input  logic [DATA_W-1:0] tail_data,
    output logic              sum,
    output logic              hit
);

    logic par_d;
    logic par_q;

    always_comb begin
        par_d = par_in;
        sum   = (^tail_data) ^ par_q;
        hit   = tail_vld & ~sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q <= 1'b0;
        end else begin
            par_q <= par_d;
        end
    end

endmodule

// File: rtl/crp_err_hold.sv
module crp_err_hold
    import crp_pkg::*;
#(
    parameter int HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic err_n
);

    localparam hold_t SPAN = hold_t'(HOLD_CYC);

    flag_t flag_d;
    flag_t flag_q;

    always_comb begin
        flag_d.cnt   = hold_next(hit, flag_q.cnt, SPAN);
        flag_d.err_n = (flag_d.cnt == hold_t'(0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q.err_n <= 1'b1;
            flag_q.cnt   <= hold_t'(0);
        end else begin
            flag_q <= flag_d;
        end
    end

    assign err_n = flag_q.err_n;

endmodule

// File: rtl/cmd_reg_par.sv
module cmd_reg_par #(
    parameter int DATA_W   = 22,
    parameter int CTRL_W   = 2,
    parameter int PAR_DLY  = 1,
    parameter int HOLD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic [CTRL_W-1:0] ctl_in,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic              par_in,
    output logic [DATA_W-1:0] dout,
    output logic [CTRL_W-1:0] ctl_out,
    output logic              cs_a_out_n,
    output logic              cs_b_out_n,
    output logic              ppo,
    output logic              err_n
);

    // Data waits PAR_DLY stages, plus one stage aligned with the parity sample.
    localparam int STAGES = PAR_DLY + 1;

    logic              tail_vld;
    logic              tail_frz;
    logic [DATA_W-1:0] tail_data;
    logic [CTRL_W-1:0] tail_ctl;
    logic [1:0]        tail_cs;
    logic              sum;
    logic              hit;

    crp_slot_pipe #(
        .DATA_W (DATA_W),
        .CTRL_W (CTRL_W),
        .STAGES (STAGES)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .ctl_in    (ctl_in),
        .cs_a_n    (cs_a_n),
        .cs_b_n    (cs_b_n),
        .tail_vld  (tail_vld),
        .tail_frz  (tail_frz),
        .tail_data (tail_data),
        .tail_ctl  (tail_ctl),
        .tail_cs   (tail_cs)
    );

    crp_par_check #(
        .DATA_W (DATA_W)
    ) u_par (
        .clk       (clk),
        .rst_n     (rst_n),
        .par_in    (par_in),
        .tail_vld  (tail_vld),
        .tail_data (tail_data),
        .sum       (sum),
        .hit       (hit)
    );

    crp_err_hold #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .err_n (err_n)
    );

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CTRL_W-1:0] ctl;
        logic [1:0]        cs_n;
        logic              ppo;
    } out_t;

    out_t out_d;
    out_t out_q;

    always_comb begin
        out_d = out_q;
        if (tail_vld) begin
            out_d.ctl  = tail_ctl;
            out_d.cs_n = tail_cs;
            if (!tail_frz) begin
                out_d.data = tail_data;
                out_d.ppo  = sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dout       = out_q.data;
    assign ctl_out    = out_q.ctl;
    assign cs_a_out_n = out_q.cs_n[0];
    assign cs_b_out_n = out_q.cs_n[1];
    assign ppo        = out_q.ppo;

endmodule

// File: rtl/crp_checker.sv
module crp_checker #(
    parameter int DATA_W   = 22,
    parameter int HOLD_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] dout,
    input logic              ppo,
    input logic              err_n,
    input logic              tail_vld,
    input logic              tail_frz,
    input logic [DATA_W-1:0] tail_data,
    input logic              sum,
    input logic              hit
);

    localparam int            GW   = $clog2(HOLD_CYC + 2) + 1;
    localparam logic [GW-1:0] GMAX = GW'(HOLD_CYC + 1);
    localparam logic [GW-1:0] GLIM = GW'(HOLD_CYC);

    // Edges since the last failing slot, saturating just past the hold span.
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= GMAX;
        end else if (hit) begin
            gap_q <= GW'(1);
        end else if (gap_q < GMAX) begin
            gap_q <= gap_q + GW'(1);
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (dout == '0 && !ppo && err_n)
                else $error("outputs not cleared under reset"); // R1
        end
    end

    AST_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_vld && !tail_frz) |=> (dout == $past(tail_data))); // R2

    AST_PPO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_vld && !tail_frz) |=> (ppo == $past(sum))); // R3

    AST_ERR_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !err_n); // R4

    AST_ERR_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |-> $past(hit)); // R4

    AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_n) == (gap_q <= GLIM)); // R5

    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_vld && tail_frz) |=> ($stable(dout) && $stable(ppo))); // R7

endmodule

bind cmd_reg_par crp_checker #(
    .DATA_W   (DATA_W),
    .HOLD_CYC (HOLD_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dout      (dout),
    .ppo       (ppo),
    .err_n     (err_n),
    .tail_vld  (tail_vld),
    .tail_frz  (tail_frz),
    .tail_data (tail_data),
    .sum       (sum),
    .hit       (hit)
);

// File: tb/cmd_reg_par_test.sv
module cmd_reg_par_test;

    localparam int DW   = 22;
    localparam int CW   = 2;
    localparam int HOLD = 2;
    localparam int LAT  = 2;   // PAR_DLY 1 plus output edge
    localparam int CLAT = 4;   // PAR_DLY 3 plus output edge

    logic          clk    = 1'b0;
    logic          rst_n  = 1'b1;
    logic [DW-1:0] din    = '0;
    logic [DW-1:0] din2   = '0;
    logic [CW-1:0] ctl_in = '0;
    logic          cs_a_n = 1'b0;
    logic          cs_b_n = 1'b0;
    logic          par_in = 1'b0;

    logic [DW-1:0] dout;
    logic [CW-1:0] ctl_out;
    logic          cs_a_out_n;
    logic          cs_b_out_n;
    logic          ppo;
    logic          err_n;

    logic [DW-1:0] d2_dout;
    logic [CW-1:0] d2_ctl;
    logic          d2_csa;
    logic          d2_csb;
    logic          d2_ppo;
    logic          d2_err_n;

    always #4 clk = ~clk;

    cmd_reg_par #(.DATA_W(DW), .CTRL_W(CW), .PAR_DLY(1), .HOLD_CYC(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .din(din), .ctl_in(ctl_in), .cs_a_n(cs_a_n),
        .cs_b_n(cs_b_n), .par_in(par_in), .dout(dout), .ctl_out(ctl_out),
        .cs_a_out_n(cs_a_out_n), .cs_b_out_n(cs_b_out_n), .ppo(ppo), .err_n(err_n)
    );

    cmd_reg_par #(.DATA_W(DW), .CTRL_W(CW), .PAR_DLY(3), .HOLD_CYC(HOLD)) down (
        .clk(clk), .rst_n(rst_n), .din(din2), .ctl_in('0), .cs_a_n(1'b0),
        .cs_b_n(1'b1), .par_in(ppo), .dout(d2_dout), .ctl_out(d2_ctl),
        .cs_a_out_n(d2_csa), .cs_b_out_n(d2_csb), .ppo(d2_ppo), .err_n(d2_err_n)
    );

    typedef struct {
        int            due;
        logic [DW-1:0] dout;
        logic [CW-1:0] ctl;
        logic          csa;
        logic          csb;
        logic          ppo;
        logic          err_n;
        string         tag;
    } exp_t;

    typedef struct {
        int    due;
        logic  err_n;
        string tag;
    } cexp_t;

    exp_t  q1[$];
    cexp_t cq[$];

    int            ecnt   = 0;
    int            checks = 0;
    int            errors = 0;
    logic          pend_par = 1'b0;
    logic [DW-1:0] m_dout = '0;
    logic          m_ppo  = 1'b0;
    int            m_h1   = 0;
    int            m_h2   = 0;

    task automatic check_val(input string tag, input string what,
                             input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        q1.delete();
        cq.delete();
        m_dout   = '0;
        m_ppo    = 1'b0;
        m_h1     = 0;
        m_h2     = 0;
        pend_par = 1'b0;
    endtask

    // Driver: one slot per clock, parity of the previous slot on par_in.
    task automatic step(input logic [DW-1:0] d, input logic [DW-1:0] d2,
                        input logic [CW-1:0] c, input logic csa, input logic csb,
                        input logic flip, input string tag);
        logic  p;
        logic  h1;
        logic  h2;
        exp_t  e;
        cexp_t ce;
        @(negedge clk);
        din    = d;
        din2   = d2;
        ctl_in = c;
        cs_a_n = csa;
        cs_b_n = csb;
        par_in = pend_par;
        p        = ~((^d) ^ (^d2)) ^ flip;
        pend_par = p;
        if (!(csa && csb)) begin
            m_dout = d;
            m_ppo  = (^d) ^ p;
        end
        h1   = ~((^d) ^ p);
        m_h1 = h1 ? HOLD : ((m_h1 > 0) ? m_h1 - 1 : 0);
        e.due = ecnt + 1 + LAT; e.dout = m_dout; e.ctl = c; e.csa = csa; e.csb = csb;
        e.ppo = m_ppo; e.err_n = (m_h1 == 0); e.tag = tag;
        q1.push_back(e);
        h2   = ~((^d2) ^ m_ppo);
        m_h2 = h2 ? HOLD : ((m_h2 > 0) ? m_h2 - 1 : 0);
        ce.due = ecnt + 1 + CLAT; ce.err_n = (m_h2 == 0); ce.tag = tag;
        cq.push_back(ce);
    endtask

    task automatic check_idle(input string tag);
        check_val(tag, "dout",  64'(dout), 64'(0));
        check_val(tag, "ppo",   64'(ppo), 64'(0));
        check_val(tag, "ctl",   64'(ctl_out), 64'(0));
        check_val(tag, "cs",    64'({cs_b_out_n, cs_a_out_n}), 64'(0));
        check_val(tag, "err_n", 64'(err_n), 64'(1));
    endtask

    // Monitor: compares results against the scoreboard at their due edge.
    always @(posedge clk) begin
        ecnt++;
        #2;
        while (q1.size() > 0 && q1[0].due <= ecnt) begin
            exp_t it;
            it = q1.pop_front();
            check_val(it.tag, "due",   64'(it.due), 64'(ecnt));
            check_val(it.tag, "dout",  64'(dout), 64'(it.dout));
            check_val(it.tag, "ctl",   64'(ctl_out), 64'(it.ctl));
            check_val(it.tag, "cs",    64'({cs_b_out_n, cs_a_out_n}), 64'({it.csb, it.csa}));
            check_val(it.tag, "ppo",   64'(ppo), 64'(it.ppo));
            check_val(it.tag, "err_n", 64'(err_n), 64'(it.err_n));
        end
        while (cq.size() > 0 && cq[0].due <= ecnt) begin
            cexp_t ct;
            ct = cq.pop_front();
            check_val(ct.tag, "cascade err_n R11", 64'(d2_err_n), 64'(ct.err_n));
        end
    end

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1 rst_n = 1'b0;
        #1 check_idle("R1");
        din = '1; cs_a_n = 1'b1; cs_b_n = 1'b1; par_in = 1'b1;
        repeat (3) @(posedge clk);
        #2 check_idle("R1");
        @(posedge clk);
        #1 rst_n = 1'b1; din = '0; cs_a_n = 1'b0; cs_b_n = 1'b0; par_in = 1'b0;

        // R10: zero inputs right after release give no change and no error.
        step('0, '0, '0, 1'b0, 1'b0, 1'b0, "R10");
        @(posedge clk);
        #3 check_idle("R10");

        // R2 R3: varied data with either chip select active.
        for (int i = 0; i < 8; i++) begin
            step(DW'(32'h2d5 * (i + 1) + 32'h7), '0, CW'(i), i[0], 1'b0, 1'b0, "R2");
        end
        for (int i = 0; i < 6; i++) begin
            step(DW'(1) << (i * 4), '0, '0, 1'b0, i[1], 1'b0, "R3");
        end

        // R4: single failing slot, then clean slots.
        step(DW'(22'h15a5a), '0, '0, 1'b0, 1'b0, 1'b1, "R4");
        for (int i = 0; i < 4; i++) begin
            step(DW'(22'h3ff00 ^ i), '0, '0, 1'b0, 1'b0, 1'b0, "R4");
        end

        // R5: failure while the flag is already low restarts the hold.
        step(DW'(22'h00f0f), '0, '0, 1'b0, 1'b0, 1'b1, "R5");
        step(DW'(22'h00f0e), '0, '0, 1'b0, 1'b0, 1'b0, "R5");
        step(DW'(22'h12345), '0, '0, 1'b0, 1'b0, 1'b1, "R5");
        for (int i = 0; i < 4; i++) begin
            step(DW'(22'h0abcd + i), '0, '0, 1'b0, 1'b0, 1'b0, "R5");
        end

        // R6: same data, changing control bits and chip selects.
        step(DW'(22'h2aaaa), '0, 2'b01, 1'b0, 1'b1, 1'b0, "R6");
        step(DW'(22'h2aaaa), '0, 2'b10, 1'b1, 1'b0, 1'b0, "R6");
        step(DW'(22'h2aaaa), '0, 2'b11, 1'b0, 1'b0, 1'b0, "R6");

        // R7: gated slots hold data and partial parity.
        step(DW'(22'h11111), '0, 2'b01, 1'b0, 1'b0, 1'b0, "R7");
        for (int i = 0; i < 3; i++) begin
            step(DW'(22'h3c3c3 + i), '0, CW'(i), 1'b1, 1'b1, 1'b0, "R7");
        end
        step(DW'(22'h00777), '0, 2'b00, 1'b0, 1'b0, 1'b0, "R7");

        // R8: failure inside a gated slot still raises the flag.
        step(DW'(22'h0f00f), '0, '0, 1'b1, 1'b1, 1'b1, "R8");
        for (int i = 0; i < 3; i++) begin
            step(DW'(22'h0f00f), '0, '0, 1'b1, 1'b1, 1'b0, "R8");
        end
        step(DW'(22'h00001), '0, '0, 1'b0, 1'b0, 1'b0, "R8");

        // R11: cascade across both data buses.
        for (int i = 0; i < 6; i++) begin
            step(DW'(22'h01234 * (i + 3)), DW'(22'h0357 << i), '0, 1'b0, 1'b0, 1'b0, "R11");
        end
        step(DW'(22'h00aa5), DW'(22'h00003), '0, 1'b0, 1'b0, 1'b1, "R11");
        for (int i = 0; i < 5; i++) begin
            step(DW'(22'h2f0f0 ^ i), DW'(22'h00100 + i), '0, 1'b0, 1'b0, 1'b0, "R11");
        end

        // R9: asynchronous reset while gating is active and the flag is low.
        step(DW'(22'h1ffff), '0, 2'b11, 1'b0, 1'b0, 1'b1, "R9");
        step(DW'(22'h05555), '0, 2'b11, 1'b1, 1'b1, 1'b0, "R9");
        step(DW'(22'h05555), '0, 2'b11, 1'b1, 1'b1, 1'b0, "R9");
        @(posedge clk);
        #1 model_reset();
        rst_n = 1'b0;
        #1 check_idle("R9");
        din = '1; cs_a_n = 1'b1; cs_b_n = 1'b1;
        repeat (2) @(posedge clk);
        #2 check_idle("R9");
        @(posedge clk);
        #1 rst_n = 1'b1; din = '0; cs_a_n = 1'b0; cs_b_n = 1'b0; par_in = 1'b0;

        step('0, '0, '0, 1'b0, 1'b0, 1'b0, "R10");
        @(posedge clk);
        #3 check_idle("R10");
        for (int i = 0; i < 5; i++) begin
            step(DW'(22'h00321 << i), DW'(i), '0, 1'b0, 1'b0, 1'b0, "R2");
        end

        // Drain: parity for the last slot, then let the scoreboard empty.
        @(negedge clk);
        par_in = pend_par;
        din    = '0;
        din2   = '0;
        repeat (8) @(posedge clk);
        #3 check_val("R2", "pending", 64'(q1.size() + cq.size()), 64'(0));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule